// File: doc/BRIEF.md
# Modem Handshake Control and Status

This block drives the four active-low modem handshake outputs of a serial port from a small control register, and it reports the four active-low modem inputs to software. The status view has two parts. The upper four bits show the present, complemented level of each input. The lower four bits are sticky flags that record changes since the last status read. Any set flag raises a modem-status interrupt request. A read strobe clears the flags.

A loopback mode supports self-test without touching the line. In this mode the control bits are fed back internally onto the input paths, and the external outputs are parked at their inactive level. The pins seen from outside are ignored while loopback is on. Every input path, including the loopback path, passes through a configurable synchronizer before its edges are detected.

Top module: `modem_line_ctl`

## Requirements
- R1: After reset, with all input pins high, `status` is 0x00, `msIrq` is 0 and all four outputs (`dtrN`, `rtsN`, `out1N`, `out2N`) are 1.
- R2: A write through `ctrlWe` loads `ctrlWdata` at the clock edge. When loopback is off, control bit 0 drives `dtrN`, bit 1 drives `rtsN`, bit 2 drives `out1N` and bit 3 drives `out2N`. A set bit gives a 0 on the pin and a clear bit gives a 1.
- R3: When control bit 4 (loopback) is set, all four outputs are 1, whatever control bits 0 to 3 hold.
- R4: In loopback the input paths take the control bits instead of the pins. Bit 1 feeds CTS, bit 0 feeds DSR, bit 2 feeds RI and bit 3 feeds DCD, each as an active (low) level when the bit is set. The external input pins have no effect on `status` in this mode.
- R5: Status bits 4, 5, 6 and 7 are the inverted synchronized levels of CTS, DSR, RI and DCD, in that order.
- R6: Status bits 0, 1 and 3 are set when CTS, DSR or DCD, respectively, changes level in either direction. They stay set until they are cleared by a read.
- R7: Status bit 2 is set only when the RI input goes from low to high. A high-to-low change leaves it clear.
- R8: `msIrq` is 1 exactly when any of status bits 0 to 3 is 1.
- R9: A cycle with `statRd` high clears status bits 0 to 3 at the next edge. Bits 4 to 7 are not affected.
- R10: A change detected in the same cycle as a read sets its flag, and that flag stays set after the clear.
- R11: With the default two synchronizer stages, a pin change made between edges shows in bits 4 to 7 after the second rising edge, and in the change flag after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWe | input | 1 | Loads the control register |
| ctrlWdata | input | 5 | New control value: bits 0 to 3 are the outputs, bit 4 is loopback |
| statRd | input | 1 | Status read strobe; clears the change flags |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring indicator pin, active low |
| dcdN | input | 1 | Carrier-detect pin, active low |
| dtrN | output | 1 | Data-terminal-ready pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| out1N | output | 1 | General-purpose output 1, active low |
| out2N | output | 1 | General-purpose output 2, active low |
| status | output | 8 | Live input levels (bits 7:4) and change flags (bits 3:0) |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
The bench targets the ring flag's direction sensitivity. A design that flags both RI edges, or only the wrong one, shows bit 2 after the falling step. It then misses bit 2 after the rising step. The bench also targets the crossed loopback mapping: a design that wires RTS to DSR, or lets an external pin leak through, produces the wrong upper nibble while the outside pins are held at opposite levels. It checks that a read arriving in the same cycle as a new edge keeps the new flag while clearing an older one. A design that gives priority to the clear loses the event. The bench also measures the synchronizer latency cycle by cycle. An extra stage, or a missing one, moves both the level bit and the flag by one edge.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int CTRL_W    = 5;
  localparam int NUM_LINES = 4;
  localparam int STAT_W    = 2 * NUM_LINES;

  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  // input line indices (status bit = index for flag, index+4 for level)
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  typedef logic [CTRL_W-1:0]    ctrlWord_t;
  typedef logic [NUM_LINES-1:0] lineVec_t;

  typedef struct packed {
    logic     loopEn;
    lineVec_t loopLinesN;
    logic     clearFlags;
  } ctrlStrobes_t;
endpackage

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
  import modem_line_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWe,
  input  ctrlWord_t    ctrlWdata,
  input  logic         statRd,
  output lineVec_t     outPinsN,
  output ctrlStrobes_t strobes
);
  ctrlWord_t ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWe) ctrlQ <= ctrlWdata;
  end

  logic loopOn;
  assign loopOn = ctrlQ[CB_LOOP];

  // outputs in {out2, out1, rts, dtr} order, parked high in loopback
  always_comb begin
    outPinsN = '1;
    if (!loopOn) begin
      outPinsN[0] = ~ctrlQ[CB_DTR];
      outPinsN[1] = ~ctrlQ[CB_RTS];
      outPinsN[2] = ~ctrlQ[CB_OUT1];
      outPinsN[3] = ~ctrlQ[CB_OUT2];
    end
  end

  // internal crossbar feeding the input lines during loopback
  always_comb begin
    strobes.loopEn             = loopOn;
    strobes.loopLinesN[LN_CTS] = ~ctrlQ[CB_RTS];
    strobes.loopLinesN[LN_DSR] = ~ctrlQ[CB_DTR];
    strobes.loopLinesN[LN_RI]  = ~ctrlQ[CB_OUT1];
    strobes.loopLinesN[LN_DCD] = ~ctrlQ[CB_OUT2];
    strobes.clearFlags         = statRd;
  end

  assert_loop_parks_outputs_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata[CB_LOOP]) |=> (outPinsN == '1));

  assert_write_drives_dtr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !ctrlWdata[CB_LOOP]) |=> (outPinsN[0] == !$past(ctrlWdata[CB_DTR])));
endmodule

// File: rtl/modem_line_datapath.sv
module modem_line_datapath
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineVec_t          pinsN,
  input  ctrlStrobes_t      strobes,
  output logic [STAT_W-1:0] status,
  output logic              msIrq
);
  lineVec_t rawN, syncN, prevN, events, flags;

  assign rawN = strobes.loopEn ? strobes.loopLinesN : pinsN;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[i]};
    end
    assign syncN[i] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= syncN;
  end

  // change detection: any edge on CTS/DSR/DCD, low-to-high pin edge on RI
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_evt
    if (i == LN_RI) begin : g_ring
      assign events[i] = syncN[i] & ~prevN[i];
    end else begin : g_delta
      assign events[i] = syncN[i] ^ prevN[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~{NUM_LINES{strobes.clearFlags}}) | events;
  end

  assign status = {~syncN, flags};
  assign msIrq  = |flags;

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flags[LN_CTS] && !strobes.clearFlags) |=> flags[LN_CTS]);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearFlags && events == '0) |=> (flags == '0));

  assert_event_kept_on_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (events[LN_DSR]) |=> flags[LN_DSR]);

  assert_ring_fall_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!syncN[LN_RI] && prevN[LN_RI] && strobes.clearFlags) |=> !flags[LN_RI]);
endmodule

// File: rtl/modem_line_ctl.sv
module modem_line_ctl
  import modem_line_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [4:0] ctrlWdata,
  input  logic       statRd,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  output logic       dtrN,
  output logic       rtsN,
  output logic       out1N,
  output logic       out2N,
  output logic [7:0] status,
  output logic       msIrq
);
  ctrlStrobes_t strobes;
  lineVec_t     outPinsN;
  lineVec_t     pinsN;

  assign pinsN = {dcdN, riN, dsrN, ctsN};

  modem_line_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .statRd    (statRd),
    .outPinsN  (outPinsN),
    .strobes   (strobes)
  );

  modem_line_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinsN   (pinsN),
    .strobes (strobes),
    .status  (status),
    .msIrq   (msIrq)
  );

  assign dtrN  = outPinsN[0];
  assign rtsN  = outPinsN[1];
  assign out1N = outPinsN[2];
  assign out2N = outPinsN[3];

  assert_irq_matches_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    msIrq == (status[3:0] != 4'b0000));
endmodule

// File: tb/modem_line_ctl_test.sv
module modem_line_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 9;

  // {pins {dcdN,riN,dsrN,ctsN}, ctrl[4:0], expected status, expected {out2N,out1N,rtsN,dtrN}}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'b1110, 5'b00000, 8'h11, 4'b1111},
    {4'b1100, 5'b00011, 8'h32, 4'b1100},
    {4'b1101, 5'b01100, 8'h21, 4'b0011},
    {4'b0101, 5'b00000, 8'hA8, 4'b1111},
    {4'b0001, 5'b00000, 8'hE0, 4'b1111},
    {4'b0101, 5'b00000, 8'hA4, 4'b1111},
    {4'b1111, 5'b10010, 8'h1B, 4'b1111},
    {4'b0000, 5'b11101, 8'hEB, 4'b1111},
    {4'b1111, 5'b00000, 8'h0E, 4'b1111}
  };

  logic clk = 0, rstN = 0, ctrlWe = 0, statRd = 0;
  logic [4:0] ctrlWdata = '0;
  logic ctsN = 1, dsrN = 1, riN = 1, dcdN = 1;
  logic dtrN, rtsN, out1N, out2N, msIrq;
  logic [7:0] status;
  int compared = 0, mismatched = 0, cycles = 0;

  modem_line_ctl uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .statRd(statRd),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .dtrN(dtrN), .rtsN(rtsN), .out1N(out1N), .out2N(out2N),
    .status(status), .msIrq(msIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic readStatus();
    @(negedge clk) statRd = 1;
    @(posedge clk);
    @(negedge clk) statRd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'b0, msIrq}, 8'h00);
    check("R1 outputs", {4'b0, out2N, out1N, rtsN, dtrN}, 8'h0F);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {dcdN, riN, dsrN, ctsN} = VEC[v][20:17];
      ctrlWdata = VEC[v][16:12];
      ctrlWe = 1;
      @(posedge clk);
      @(negedge clk) ctrlWe = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check($sformatf("R4/R5/R6/R7 vec%0d status", v), status, VEC[v][11:4]);
      check($sformatf("R2/R3 vec%0d outputs", v), {4'b0, out2N, out1N, rtsN, dtrN}, {4'b0, VEC[v][3:0]});
      check($sformatf("R8 vec%0d irq", v), {7'b0, msIrq}, {7'b0, (VEC[v][7:4] != 4'b0)});
      readStatus();
      check($sformatf("R9 vec%0d after read", v), status, VEC[v][11:4] & 8'hF0);
    end

    // R11 synchronizer latency on CTS
    @(negedge clk) ctsN = 0;
    @(posedge clk); @(negedge clk);
    check("R11 one edge", status, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R11 two edges", status, 8'h10);
    @(posedge clk); @(negedge clk);
    check("R11 three edges", status, 8'h11);

    // R10 read coinciding with a new DSR edge; older CTS flag clears
    @(negedge clk) dsrN = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) statRd = 1;
    @(posedge clk);
    @(negedge clk) statRd = 0;
    check("R10 edge during read", status, 8'h32);
    readStatus();
    check("R9 final clear", status, 8'h30);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule